// File: doc/BRIEF.md
# Flag-Gated Adaptive Double-Error BCH Corrector

This block is the correction stage of an adaptive double-error-correcting, triple-error-detecting BCH decoder for a 64-bit data word. Syndrome generation and error counting happen upstream. They deliver the received data bits, the first syndrome S1, the third syndrome S3, the cubic check term (S1^3 + S3) and a 2-bit error-count flag. The flag picks one of three outcomes. The word can pass unchanged, have one bit repaired, or have two bits repaired. A flag of 3 marks a word that cannot be corrected.

The block has two holding register groups: one for the single-error path and one for the double-error path. A group loads only when the flag selects its corrector, so at most one corrector sees new operands in a cycle. The no-error and uncorrectable cases never disturb either corrector and select an all-zero error vector.

`clk_i` is the capture clock, meaning the inverted dedicated decoder clock. Its high phase must cover the upstream syndrome and classifier delay. The block registers the presented inputs on its rising edge and shows the corrected word one cycle later.

Top module: `bch_adapt_corr`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `uncorr_o` are 0 and `data_o` is all zeros.
- R2: `valid_o` is 1 in the cycle after a capture edge at which `vld_i` was 1, and 0 after an edge at which `vld_i` was 0.
- R3: Flag value 0 (no error) gives `data_o` equal to the captured `rx_data_i` and `uncorr_o` low, whatever the syndrome inputs carry.
- R4: Flag value 3 (three or more errors) gives `uncorr_o` high and `data_o` equal to the captured `rx_data_i`. For flags 0, 1 and 2, `uncorr_o` is low.
- R5: Flag value 1 flips data bit i when S1 equals alpha^i, for i in 0..63. Here alpha is a root of x^7+x^3+1 and field elements are 7-bit polynomial-basis vectors, with bit k being the coefficient of alpha^k. S3 and the cubic term have no effect on this path.
- R6: Flag value 1 with an S1 that matches no alpha^i for i in 0..63 (an error in a check-bit position, e.g. alpha^100) leaves the data unchanged.
- R7: Flag value 2 flips data bits i and j when S1 = alpha^i + alpha^j and the cubic term equals S1^3 + S3. If one of the two exponents is 64 or above, only the data bit is flipped. With the default `DE_USE_CUBIC`=1, `s3_i` has no effect.
- R8: An edge with `vld_i` low loads nothing: `data_o` and `uncorr_o` keep their values.
- R9: Flag value 2 with S1 equal to zero flips no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock (inverted decoder clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Inputs are settled and presented this cycle |
| rx_data_i | input | 64 | Received data bits |
| s1_i | input | 7 | First syndrome S1 |
| s3_i | input | 7 | Third syndrome S3 |
| cubic_i | input | 7 | Cubic check term S1^3 + S3 |
| flag_i | input | 2 | Error count: 0 none, 1 single, 2 double, 3 uncorrectable |
| data_o | output | 64 | Corrected data |
| valid_o | output | 1 | Corrected data valid |
| uncorr_o | output | 1 | Word was classified as uncorrectable |

## Verification
The holding registers are hard to reach from the ports. A gated register keeps its old operands while the other path or the bypass is active, and the outputs hide that state. The bench therefore shows freezing through the one visible effect: it presents a cycle with `vld_i` low but with a double-error flag and fresh, different syndromes and data, then confirms that the previous output survives. Mismatched flag and syndrome pairs also appear, such as a no-error flag with a nonzero S1, a single error in a check-bit position, and a double flag with S1 of zero. These confirm that the flag alone picks the path.

// File: rtl/bch_adapt_pkg.sv
package bch_adapt_pkg;

  localparam int unsigned GF_M = 7;
  // x^7 + x^3 + 1, low terms only
  localparam logic [GF_M-1:0] GF_POLY = 7'h09;

  typedef enum logic [1:0] {
    FLG_NONE   = 2'b00,
    FLG_SINGLE = 2'b01,
    FLG_DOUBLE = 2'b10,
    FLG_MULTI  = 2'b11
  } err_flag_e;

  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                             input logic [GF_M-1:0] b);
    logic [GF_M-1:0] r;
    r = '0;
    for (int k = GF_M - 1; k >= 0; k--) begin
      r = {r[GF_M-2:0], 1'b0} ^ (r[GF_M-1] ? GF_POLY : '0);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [GF_M-1:0] gf_alpha_pow(input int unsigned e);
    logic [GF_M-1:0] r;
    r = {{(GF_M-1){1'b0}}, 1'b1};
    for (int unsigned n = 0; n < e; n++) begin
      r = {r[GF_M-2:0], 1'b0} ^ (r[GF_M-1] ? GF_POLY : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/bch_hold_reg.sv
module bch_hold_reg #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

endmodule

// File: rtl/bch_se_corr.sv
module bch_se_corr
  import bch_adapt_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [GF_M-1:0]   s1_i,
  output logic [DATA_W-1:0] err_o
);

  // compare S1 with each H1 column alpha^i
  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [GF_M-1:0] COL = gf_alpha_pow(i);
    assign err_o[i] = (s1_i == COL);
  end

endmodule

// File: rtl/bch_de_corr.sv
module bch_de_corr
  import bch_adapt_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [GF_M-1:0]   s1_i,
  input  logic [GF_M-1:0]   cub_i,
  output logic [DATA_W-1:0] err_o
);

  logic [GF_M-1:0] s1_sq;
  logic            s1_nz;

  assign s1_sq = gf_mul(s1_i, s1_i);
  assign s1_nz = |s1_i;

  // root test S1*x^2 + S1^2*x + (S1^3+S3) == 0, x = alpha^i
  for (genvar i = 0; i < DATA_W; i++) begin : g_loc
    localparam logic [GF_M-1:0] X1 = gf_alpha_pow(i);
    localparam logic [GF_M-1:0] X2 = gf_alpha_pow((2 * i) % ((1 << GF_M) - 1));
    logic [GF_M-1:0] val;
    assign val      = gf_mul(s1_i, X2) ^ gf_mul(s1_sq, X1) ^ cub_i;
    assign err_o[i] = s1_nz && (val == '0);
  end

endmodule

// File: rtl/bch_adapt_corr.sv
module bch_adapt_corr
  import bch_adapt_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter bit          DE_USE_CUBIC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [GF_M-1:0]   s1_i,
  input  logic [GF_M-1:0]   s3_i,
  input  logic [GF_M-1:0]   cubic_i,
  input  logic [1:0]        flag_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              uncorr_o
);

  localparam int unsigned DE_W = 2 * GF_M;

  err_flag_e         flag_in, flag_q;
  logic              ld_se, ld_de;
  logic [GF_M-1:0]   de_term;
  logic [GF_M-1:0]   s1_se_q;
  logic [DE_W-1:0]   de_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic [DATA_W-1:0] err_se, err_de, err_sel;

  assign flag_in = err_flag_e'(flag_i);

  // per-group load enables: INV + AND of flag bits
  assign ld_se = vld_i & ~flag_i[1] &  flag_i[0];
  assign ld_de = vld_i &  flag_i[1] & ~flag_i[0];

  assign de_term = DE_USE_CUBIC ? cubic_i
                                : (gf_mul(gf_mul(s1_i, s1_i), s1_i) ^ s3_i);

  bch_hold_reg #(.WIDTH(GF_M)) u_se_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_se),
    .d_i    (s1_i),
    .q_o    (s1_se_q)
  );

  bch_hold_reg #(.WIDTH(DE_W)) u_de_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_de),
    .d_i    ({s1_i, de_term}),
    .q_o    (de_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      flag_q  <= FLG_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= vld_i;
      if (vld_i) begin
        data_q <= rx_data_i;
        flag_q <= flag_in;
      end
    end
  end

  bch_se_corr #(.DATA_W(DATA_W)) u_se_corr (
    .s1_i  (s1_se_q),
    .err_o (err_se)
  );

  bch_de_corr #(.DATA_W(DATA_W)) u_de_corr (
    .s1_i  (de_q[DE_W-1:GF_M]),
    .cub_i (de_q[GF_M-1:0]),
    .err_o (err_de)
  );

  // 3:1 error vector select
  always_comb begin
    unique case (flag_q)
      FLG_SINGLE: err_sel = err_se;
      FLG_DOUBLE: err_sel = err_de;
      default:    err_sel = '0;
    endcase
  end

  assign data_o   = data_q ^ err_sel;
  assign valid_o  = valid_q;
  assign uncorr_o = (flag_q == FLG_MULTI);

endmodule

// File: rtl/bch_adapt_corr_chk.sv
module bch_adapt_corr_chk
  import bch_adapt_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic [GF_M-1:0]   s1_i,
  input logic [1:0]        flag_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              uncorr_o
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!valid_o && !uncorr_o && data_o == '0);
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> valid_o);

  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !valid_o);

  p_bypass_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && flag_i == 2'b00) |=> (data_o == $past(rx_data_i) && !uncorr_o));

  p_bypass_multi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && flag_i == 2'b11) |=> (uncorr_o && data_o == $past(rx_data_i)));

  p_one_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && flag_i == 2'b01) |=> ($countones(data_o ^ $past(rx_data_i)) <= 1 && !uncorr_o));

  p_two_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && flag_i == 2'b10) |=> ($countones(data_o ^ $past(rx_data_i)) <= 2 && !uncorr_o));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(data_o) && $stable(uncorr_o)));

  p_zero_s1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && flag_i == 2'b10 && s1_i == '0) |=> (data_o == $past(rx_data_i)));

endmodule

bind bch_adapt_corr bch_adapt_corr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vld_i     (vld_i),
  .rx_data_i (rx_data_i),
  .s1_i      (s1_i),
  .flag_i    (flag_i),
  .data_o    (data_o),
  .valid_o   (valid_o),
  .uncorr_o  (uncorr_o)
);

// File: tb/bch_adapt_corr_tb.sv
module bch_adapt_corr_tb;

  localparam int DW = 64;
  localparam int NV = 12;

  // {flag[1:0], nerr[1:0], pos_a[6:0], pos_b[6:0], seed[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 2'd0, 7'd0,   7'd0,   8'hA5},
    {2'd1, 2'd1, 7'd0,   7'd0,   8'h3C},
    {2'd1, 2'd1, 7'd63,  7'd0,   8'hF0},
    {2'd1, 2'd1, 7'd100, 7'd0,   8'h11},
    {2'd2, 2'd2, 7'd0,   7'd63,  8'h5A},
    {2'd2, 2'd2, 7'd5,   7'd6,   8'hC3},
    {2'd2, 2'd2, 7'd3,   7'd100, 8'h77},
    {2'd2, 2'd2, 7'd31,  7'd32,  8'h0F},
    {2'd3, 2'd2, 7'd10,  7'd20,  8'h99},
    {2'd0, 2'd1, 7'd7,   7'd0,   8'hE1},
    {2'd1, 2'd1, 7'd40,  7'd0,   8'h2D},
    {2'd2, 2'd2, 7'd1,   7'd62,  8'hB4}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          vld_i = 1'b0;
  logic [DW-1:0] rx_data_i = '0;
  logic [6:0]    s1_i = '0, s3_i = '0, cubic_i = '0;
  logic [1:0]    flag_i = '0;
  logic [DW-1:0] data_o;
  logic          valid_o, uncorr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  bch_adapt_corr u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld_i),
    .rx_data_i (rx_data_i),
    .s1_i      (s1_i),
    .s3_i      (s3_i),
    .cubic_i   (cubic_i),
    .flag_i    (flag_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .uncorr_o  (uncorr_o)
  );

  function automatic logic [6:0] tb_mul(input logic [6:0] a, input logic [6:0] b);
    logic [6:0] acc = '0;
    logic [6:0] sh = a;
    for (int k = 0; k < 7; k++) begin
      if (b[k]) acc ^= sh;
      sh = sh[6] ? ({sh[5:0], 1'b0} ^ 7'h09) : {sh[5:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [6:0] tb_apow(input int e);
    logic [6:0] r = 7'd1;
    for (int k = 0; k < (e % 127); k++) r = tb_mul(r, 7'h02);
    return r;
  endfunction

  task automatic chk64(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s data_o actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] orig, rx, last_out;
    logic [6:0]    s1, s3;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk1("R1", "valid_o", valid_o, 1'b0);
    chk1("R1", "uncorr_o", uncorr_o, 1'b0);
    chk64("R1", data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk1("R2", "valid_o idle", valid_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] fl, ne;
      int pa, pb;
      string tag;
      logic [DW-1:0] exp;
      fl = VEC[v][25:24];
      ne = VEC[v][23:22];
      pa = int'(VEC[v][21:15]);
      pb = int'(VEC[v][14:8]);
      orig = {8{VEC[v][7:0]}} ^ 64'h0123_4567_89AB_CDEF;
      rx = orig;
      s1 = '0;
      s3 = '0;
      if (ne >= 2'd1) begin
        s1 ^= tb_apow(pa);
        s3 ^= tb_apow(3 * pa);
        if (pa < DW) rx[pa] = ~rx[pa];
      end
      if (ne >= 2'd2) begin
        s1 ^= tb_apow(pb);
        s3 ^= tb_apow(3 * pb);
        if (pb < DW) rx[pb] = ~rx[pb];
      end
      rx_data_i = rx;
      s1_i      = s1;
      s3_i      = s3;
      cubic_i   = tb_mul(tb_mul(s1, s1), s1) ^ s3;
      flag_i    = fl;
      vld_i     = 1'b1;
      case (fl)
        2'd0: begin tag = "R3"; exp = rx; end
        2'd1: begin tag = (pa < DW) ? "R5" : "R6"; exp = orig; end
        2'd2: begin tag = "R7"; exp = orig; end
        default: begin tag = "R4"; exp = rx; end
      endcase
      @(negedge clk_i);
      chk64(tag, data_o, exp);
      chk1(tag, "uncorr_o", uncorr_o, fl == 2'd3);
      chk1("R2", "valid_o", valid_o, 1'b1);
      last_out = data_o;
      if (v == 8) begin
        // R8: idle cycle with fresh double-error inputs must not load
        vld_i     = 1'b0;
        flag_i    = 2'd2;
        rx_data_i = ~rx;
        s1_i      = tb_apow(4) ^ tb_apow(9);
        cubic_i   = 7'h55;
        @(negedge clk_i);
        chk1("R8", "valid_o", valid_o, 1'b0);
        chk64("R8", data_o, last_out);
        chk1("R8", "uncorr_o", uncorr_o, 1'b1);
      end
    end

    // R9: double flag with S1 of zero
    rx_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    s1_i = '0;
    s3_i = 7'h13;
    cubic_i = '0;
    flag_i = 2'd2;
    vld_i = 1'b1;
    @(negedge clk_i);
    chk64("R9", data_o, 64'hDEAD_BEEF_0BAD_F00D);

    // R7: S3 has no effect when the cubic term is used
    rx_data_i = 64'h0;
    s1_i = tb_apow(12) ^ tb_apow(50);
    s3_i = 7'h7F;
    cubic_i = tb_mul(tb_mul(s1_i, s1_i), s1_i) ^ tb_apow(36) ^ tb_apow(150);
    flag_i = 2'd2;
    @(negedge clk_i);
    chk64("R7", data_o, (64'd1 << 12) | (64'd1 << 50));

    // R1: asynchronous reset mid-run
    vld_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk1("R1", "valid_o", valid_o, 1'b0);
    chk64("R1", data_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule